// File: doc/BRIEF.md
# Timer Global Control and Prescaler

This block is the shared front end of a 28-channel timer. It holds the module-wide control bits and one 8-bit prescaler. From these it makes a single clock-enable pulse (`tick`) that every channel advances on, and it fans that pulse out per channel through a channel-disable mask. It also keeps a global time-base counter that steps on each tick while enabled, and it offers one register that gathers one flag bit from each channel.

Software reaches the block through a plain register port. A write is one cycle with `wr_en` high. A read is combinational on `addr`. Four words are decoded:

| Address | Word |
|---|---|
| 0 | Control |
| 1 | Channel flags (read-only) |
| 2 | Channel disable |
| 3 | Time base (read-only) |

Any write to the control word restarts the prescaler, so a new ratio or a new set of gating bits starts from a clean phase.

Top module: `tmr_glob_ctl`

## Requirements
- R1: After reset the control word, the channel-disable word and the time base all read 0, and neither `tick` nor any `ch_tick` bit is high.
- R2: While the prescaler-enable bit (control bit 0) is 0, `tick` and every `ch_tick` bit stay 0.
- R3: With control bit 0 set and the other gating bits clear, `tick` is high for exactly one cycle in every V+1 cycles. Here V is control bits 15:8, in the range 0 to 255. A write to the control word restarts the count, so the first tick falls in the (V+1)-th cycle after the write edge. Over the first M cycles after the write there are floor(M/(V+1)) ticks.
- R4: While the module-off bit (control bit 1) is 1, no tick is produced on any output.
- R5: While the freeze bit (control bit 2) and the `debug_mode` input are both 1, ticks stop and the prescaler phase is held. When `debug_mode` falls, counting resumes from the held phase. The freeze bit alone has no effect.
- R6: Bit i of the channel-disable word (address 2, bits 27:0) set to 1 forces `ch_tick[i]` to 0. When the bit is 0, `ch_tick[i]` equals `tick`. The word reads back as written and appears on `ch_dis`.
- R7: While the time-base enable (control bit 3, also on `gtb_en`) is 1, `time_base` advances by one at each clock edge where `tick` is high. While it is 0, `time_base` holds. Address 3 reads `time_base`.
- R8: Address 1 reads the current `ch_flags` input in bits 27:0, with the upper bits 0.
- R9: Writes to addresses 1 and 3 change no register, no output and no readable value.
- R10: Address 0 reads back the stored control fields at the bit positions given above, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| debug_mode | input | 1 | Debug halt indication; freezes ticks when the freeze bit is set |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word address |
| wdata | input | 32 | Write data |
| ch_flags | input | 28 | One flag bit from each channel |
| rdata | output | 32 | Read data for `addr` |
| tick | output | 1 | Prescaled clock-enable pulse |
| ch_tick | output | 28 | Per-channel clock enable after the disable mask |
| ch_dis | output | 28 | Channel-disable word |
| gtb_en | output | 1 | Global time-base enable |
| time_base | output | 16 | Global time-base counter |

## Verification
A control write and a prescaler tick can land in the same cycle. When they do, the reload must win over the wrap: the tick of that cycle still counts toward the time base, and the new period is measured from the write edge. The bench provokes this on purpose by running the divider at ratio 1 and then writing a new ratio. It also provokes it at random, because every random trial writes the control word while the previous setting is still ticking. Each case is judged by counting the ticks seen after the write against floor(M/(V+1)), and by checking the time-base delta against the ticks it should have seen.

// File: rtl/tmr_glob_ctl.sv
module tmr_glob_ctl #(
  parameter int NCH = 28,
  parameter int PW  = 8,
  parameter int CW  = 16,
  parameter int DW  = 32,
  parameter int AW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           debug_mode,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  input  logic [NCH-1:0] ch_flags,
  output logic [DW-1:0]  rdata,
  output logic           tick,
  output logic [NCH-1:0] ch_tick,
  output logic [NCH-1:0] ch_dis,
  output logic           gtb_en,
  output logic [CW-1:0]  time_base
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_FLAG = AW'(1);
  localparam logic [AW-1:0] A_DIS  = AW'(2);
  localparam logic [AW-1:0] A_TB   = AW'(3);
  localparam int B_PEN = 0;
  localparam int B_OFF = 1;
  localparam int B_FRZ = 2;
  localparam int B_GTB = 3;
  localparam int B_VAL = 8;

  logic          pre_en, mod_off, frz;
  logic [PW-1:0] pre_val;
  logic [PW-1:0] cnt;
  logic          wr_ctrl, wr_dis, run;
  logic [DW-1:0] ctrl_word;
  logic          unused_wbits;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_dis  = wr_en && (addr == A_DIS);
  assign run     = pre_en && !mod_off && !(frz && debug_mode);
  assign tick    = run && (cnt == pre_val);
  assign ch_tick = {NCH{tick}} & ~ch_dis;
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_en  <= 1'b0;
      mod_off <= 1'b0;
      frz     <= 1'b0;
      gtb_en  <= 1'b0;
      pre_val <= '0;
    end else if (wr_ctrl) begin
      pre_en  <= wdata[B_PEN];
      mod_off <= wdata[B_OFF];
      frz     <= wdata[B_FRZ];
      gtb_en  <= wdata[B_GTB];
      pre_val <= wdata[B_VAL +: PW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ch_dis <= '0;
    else if (wr_dis)
      ch_dis <= wdata[NCH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (wr_ctrl || mod_off)
      cnt <= '0;
    else if (run)
      cnt <= tick ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      time_base <= '0;
    else if (tick && gtb_en)
      time_base <= time_base + 1'b1;
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[B_PEN] = pre_en;
    ctrl_word[B_OFF] = mod_off;
    ctrl_word[B_FRZ] = frz;
    ctrl_word[B_GTB] = gtb_en;
    ctrl_word[B_VAL +: PW] = pre_val;
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = ctrl_word;
      A_FLAG:  rdata = DW'(ch_flags);
      A_DIS:   rdata = DW'(ch_dis);
      A_TB:    rdata = DW'(time_base);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_glob_ctl_chk.sv
module tmr_glob_ctl_chk #(
  parameter int NCH = 28,
  parameter int PW  = 8,
  parameter int CW  = 16,
  parameter int AW  = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           debug_mode,
  input logic           wr_en,
  input logic [AW-1:0]  addr,
  input logic           tick,
  input logic [NCH-1:0] ch_tick,
  input logic [NCH-1:0] ch_dis,
  input logic           gtb_en,
  input logic [CW-1:0]  time_base,
  input logic           pre_en,
  input logic           mod_off,
  input logic           frz,
  input logic [PW-1:0]  pre_val,
  input logic [PW-1:0]  cnt
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en && (addr == AW'(0));

  a_r2_no_tick_unprescaled: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_en |-> (!tick && ch_tick == '0));

  a_r3_lone_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pre_val != '0 && !ctrl_wr) |=> !tick);

  a_r4_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    mod_off |-> (!tick && ch_tick == '0));

  a_r5_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && debug_mode && !mod_off && !ctrl_wr) |=> $stable(cnt));

  a_r6_masked_channels: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_tick & ch_dis) == '0);

  a_r7_base_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!gtb_en || !tick) |=> $stable(time_base));
endmodule

bind tmr_glob_ctl tmr_glob_ctl_chk #(.NCH(NCH), .PW(PW), .CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .debug_mode(debug_mode), .wr_en(wr_en), .addr(addr),
  .tick(tick), .ch_tick(ch_tick), .ch_dis(ch_dis), .gtb_en(gtb_en),
  .time_base(time_base), .pre_en(pre_en), .mod_off(mod_off), .frz(frz),
  .pre_val(pre_val), .cnt(cnt)
);

// File: tb/tmr_glob_ctl_test.sv
module tmr_glob_ctl_test;
  localparam int CLK_NS = 10;
  localparam int NCH = 28;
  localparam logic [31:0] CHMASK = (32'h1 << NCH) - 1;

  logic clk = 1'b0, rst_n = 1'b0, debug_mode = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [NCH-1:0] ch_flags = '0;
  logic [31:0] rdata;
  logic tick, gtb_en;
  logic [NCH-1:0] ch_tick, ch_dis;
  logic [15:0] time_base;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  tmr_glob_ctl uut (
    .clk(clk), .rst_n(rst_n), .debug_mode(debug_mode), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .ch_flags(ch_flags), .rdata(rdata),
    .tick(tick), .ch_tick(ch_tick), .ch_dis(ch_dis), .gtb_en(gtb_en),
    .time_base(time_base)
  );

  function automatic logic [31:0] ctrl(bit pen, bit off, bit fz, bit gtb, int v);
    return {16'h0, 8'(v), 4'h0, gtb, fz, off, pen};
  endfunction

  function automatic int exp_ticks(int m, int v, bit gated);
    return gated ? 0 : m / (v + 1);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic count_ticks(int m, output int n, output int nb, output logic [15:0] tb0,
                             output logic [15:0] tb1);
    n = 0; nb = 0; tb0 = '0; tb1 = '0;
    for (int j = 1; j <= m; j++) begin
      @(negedge clk);
      if (j == 1) tb0 = time_base;
      if (j == m) tb1 = time_base;
      if (tick) begin
        n++;
        if (j < m) nb++;
      end
    end
  endtask

  initial begin
    #(CLK_NS * 190000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, pat;
    int n, nb, first;
    logic [15:0] tb0, tb1, tbs;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(2'd0, d); check(d == 0, "R1 ctrl", d, 0);
    rd(2'd2, d); check(d == 0, "R1 dis", d, 0);
    rd(2'd3, d); check(d == 0, "R1 tb", d, 0);
    check(!tick && ch_tick == 0, "R1 tick", ch_tick, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!tick && ch_tick == 0, "R1 tick after release", tick, 0);

    // R2 no prescaler enable
    wr(2'd0, ctrl(0, 0, 0, 1, 0));
    count_ticks(50, n, nb, tb0, tb1);
    check(n == 0, "R2 gated", n, 0);

    // R3 directed ratios and R10 readback
    wr(2'd0, ctrl(1, 0, 0, 0, 0));
    rd(2'd0, d); check(d == 32'h0000_0001, "R10 readback", d, 32'h1);
    count_ticks(20, n, nb, tb0, tb1);
    check(n == 20, "R3 ratio 1", n, 20);
    wr(2'd0, ctrl(1, 0, 0, 1, 255));
    rd(2'd0, d); check(d == 32'h0000_ff09, "R10 readback", d, 32'hff09);
    count_ticks(512, n, nb, tb0, tb1);
    check(n == 2, "R3 ratio 256", n, 2);
    wr(2'd0, ctrl(1, 0, 0, 0, 4));
    count_ticks(23, n, nb, tb0, tb1);
    check(n == 4, "R3 ratio 5", n, 4);

    // R3 reload on a tick cycle
    wr(2'd0, ctrl(1, 0, 0, 0, 0));
    repeat (3) @(negedge clk);
    check(tick == 1'b1, "R3 tick before reload", tick, 1);
    wr(2'd0, ctrl(1, 0, 0, 0, 3));
    first = 0;
    for (int j = 1; j <= 8; j++) begin
      @(negedge clk);
      if (tick && first == 0) first = j;
    end
    check(first == 4, "R3 first tick after reload", first, 4);

    // R4 module off
    wr(2'd0, ctrl(1, 1, 0, 1, 0));
    count_ticks(40, n, nb, tb0, tb1);
    check(n == 0 && ch_tick == 0, "R4 off", n, 0);

    // R5 freeze holds phase
    wr(2'd0, ctrl(1, 0, 1, 0, 9));
    count_ticks(5, n, nb, tb0, tb1);
    check(n == 0, "R5 pre-freeze", n, 0);
    debug_mode = 1'b1;
    count_ticks(7, n, nb, tb0, tb1);
    check(n == 0, "R5 frozen", n, 0);
    debug_mode = 1'b0;
    first = 0;
    for (int j = 1; j <= 12; j++) begin
      @(negedge clk);
      if (tick && first == 0) first = j;
    end
    check(first == 5, "R5 resume phase", first, 5);

    // R6 channel disable
    pat = $urandom & CHMASK;
    wr(2'd2, pat);
    rd(2'd2, d); check(d == pat, "R6 readback", d, pat);
    wr(2'd0, ctrl(1, 0, 0, 0, 0));
    @(negedge clk);
    check(ch_tick == ~pat[NCH-1:0] && ch_dis == pat[NCH-1:0], "R6 mask", ch_tick, ~pat[NCH-1:0]);
    wr(2'd2, 32'hffff_ffff);
    @(negedge clk);
    check(ch_tick == 0 && tick, "R6 all off", ch_tick, 0);
    wr(2'd2, 32'h0);
    @(negedge clk);
    check(ch_tick == {NCH{1'b1}}, "R6 all on", ch_tick, {NCH{1'b1}});

    // R8 flags and R9 ignored writes
    wr(2'd0, ctrl(1, 0, 0, 0, 7));
    wr(2'd2, pat);
    for (int k = 0; k < 4; k++) begin
      ch_flags = NCH'($urandom);
      rd(2'd1, d); check(d == {4'h0, ch_flags}, "R8 flags", d, {4'h0, ch_flags});
    end
    rd(2'd3, d); tbs = d[15:0];
    wr(2'd1, 32'hffff_ffff);
    wr(2'd3, 32'hffff_ffff);
    rd(2'd0, d); check(d == ctrl(1, 0, 0, 0, 7), "R9 ctrl kept", d, ctrl(1, 0, 0, 0, 7));
    rd(2'd2, d); check(d == pat, "R9 dis kept", d, pat);
    rd(2'd3, d); check(d[15:0] == tbs, "R9 tb kept", d, tbs);
    rd(2'd1, d); check(d == {4'h0, ch_flags}, "R9 flags live", d, {4'h0, ch_flags});

    // random trials: R3, R4, R5, R7
    for (int t = 0; t < 40; t++) begin
      int v, m, e;
      bit pen, off, fz, gtb, gated;
      v   = ($urandom % 3 == 0) ? int'($urandom % 256) : int'($urandom % 12);
      m   = 2 + int'($urandom % 600);
      pen = ($urandom % 4) != 0;
      off = ($urandom % 7) == 0;
      fz  = ($urandom % 3) == 0;
      gtb = $urandom % 2;
      debug_mode = $urandom % 2;
      gated = !pen || off || (fz && debug_mode);
      wr(2'd0, ctrl(pen, off, fz, gtb, v));
      count_ticks(m, n, nb, tb0, tb1);
      e = exp_ticks(m, v, gated);
      check(n == e, "R3 random ticks", n, e);
      e = gtb ? exp_ticks(m - 1, v, gated) : 0;
      check(16'(tb1 - tb0) == 16'(e), "R7 time base delta", 16'(tb1 - tb0), e);
      check(gtb_en == gtb, "R7 enable out", gtb_en, gtb);
    end
    debug_mode = 1'b0;

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule